// File: doc/BRIEF.md
# Serial Control Register Slave

A serial-port slave that gives a host access to a small bank of byte-wide control and status registers. Every transaction is framed by an active-low chip select. It carries one instruction byte, made of a read/write flag and a 7-bit register address, followed by one data byte. The block oversamples the serial clock, chip select and data pin in its own system clock domain. It captures input bits on rising serial-clock edges and changes its read data on falling edges.

Two fields of the mode register reconfigure the port while it runs. One selects whether each serial byte travels most-significant or least-significant bit first. The other selects between two pin modes: a 4-wire mode, where read data leaves on a dedicated output pin, and a 3-wire mode, where the data pin itself is turned around and driven during a read. A self-clearing software-reset bit in the mode register returns every other register to its default. A few read-only status bits come from outside the block. The stored fields drive the surrounding converter logic directly through output ports.

Top module: `spi_ctrl_regs`

## Requirements
- R1: After rst_ni is released, every register output reads 0 and neither sdio_oe_o nor sdo_oe_o is asserted.
- R2: A transaction is an instruction byte {rw, addr[6:0]} (rw=1 read, 0 write) followed by one data byte. A write changes a register only after the 16th rising serial-clock edge with cs_ni low, and clock edges after the 16th are ignored until cs_ni rises.
- R3: In a read, the first data bit is placed on the output after the falling edge that follows the 8th rising edge. Each later bit follows a falling edge, and the line does not change between falling edges.
- R4: The pin mode is mode register 0x00 bit 7. When it is 0 (4-wire), read data and its enable appear on sdo_o/sdo_oe_o. When it is 1 (3-wire), they appear on sdio_o/sdio_oe_o and sdo_oe_o stays 0. An enable is asserted only in the data phase of a read.
- R5: The bit order is 0x00 bit 6. When it is 0, both bytes are shifted MSB first. When it is 1, both bytes are shifted LSB first. This applies to the instruction byte as well as to read and write data.
- R6: The writable masks are: 0x00 = 0xD9, 0x02 = 0xFE, 0x10 = 0xFF, 0x11 = 0x3F, 0x16 = 0x78. A read of 0x02 returns sync_alarm_i in bit 0. A read of 0x15 returns sync_quad_i in bits [1:0], and writes to 0x15 are ignored.
- R7: Writes to any address other than 0x00, 0x02, 0x10, 0x11 or 0x16 change nothing. Reads of any unmapped address return 0x00.
- R8: If cs_ni rises before the 16th rising edge, the transaction is abandoned and no register changes.
- R9: Writing 0x00 with bit 5 set clears 0x02, 0x10, 0x11 and 0x16. It stores the other writable bits of that same byte into 0x00, and bit 5 always reads 0.
- R10: Sleep (bit 4), power-down (bit 3) and external reference (bit 0) of 0x00 are stored and output, and the serial port keeps working while they are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock |
| cs_ni | input | 1 | Active-low chip select |
| sdio_i | input | 1 | Serial data in (input side of the shared pin) |
| sdio_o | output | 1 | Read data on the shared pin (3-wire) |
| sdio_oe_o | output | 1 | Drive enable of the shared pin |
| sdo_o | output | 1 | Read data on the dedicated output (4-wire) |
| sdo_oe_o | output | 1 | Drive enable of the dedicated output |
| sync_alarm_i | input | 1 | Status bit read back in 0x02 bit 0 |
| sync_quad_i | input | 2 | Status field read back in 0x15 [1:0] |
| mode_cfg_o | output | 8 | Register 0x00 contents |
| dclk_cfg_o | output | 8 | Register 0x02 stored bits (bit 0 is 0) |
| mem_addr_o | output | 8 | Register 0x10 contents |
| mem_data_o | output | 6 | Register 0x11 contents |
| sync_cfg_o | output | 8 | Register 0x16 contents |

## Verification
The bench builds the block with SYNC_STAGES = 2 and MEM_DATA_W = 6. It runs the serial clock at one sixteenth of the system clock, so the synchroniser and edge-detect delay fits well inside each serial half period, and the bench can sample read bits just before each rising edge. The 6-bit data register makes the masking of 0x11's top two bits visible on readback. Because the defaults are all zero, the software reset is proven by filling every register with nonzero patterns and then watching them return to zero while the mode register keeps its new value.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam logic [6:0] A_MODE = 7'h00;
  localparam logic [6:0] A_DCLK = 7'h02;
  localparam logic [6:0] A_MADR = 7'h10;
  localparam logic [6:0] A_MDAT = 7'h11;
  localparam logic [6:0] A_SQO  = 7'h15;
  localparam logic [6:0] A_SQI  = 7'h16;

  localparam logic [7:0] M_MODE = 8'hD9;
  localparam logic [7:0] M_DCLK = 8'hFE;
  localparam logic [7:0] M_SQI  = 8'h78;

  localparam int unsigned SRST_BIT  = 5;
  localparam int unsigned LSB_BIT   = 6;
  localparam int unsigned WIRE3_BIT = 7;

  typedef struct packed {
    logic       we;
    logic [6:0] addr;
    logic [7:0] data;
  } wr_req_t;

  function automatic logic [7:0] bit_rev(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int unsigned W       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0][STAGES-1:0] chain_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= {STAGES{RST_VAL[g]}};
      else         chain_q[g] <= {chain_q[g][STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain_q[g][STAGES-1];
  end
endmodule

// File: rtl/spi_serial_engine.sv
module spi_serial_engine
  import spi_cfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_n_i,
  input  logic       sclk_i,
  input  logic       sdi_i,
  input  logic       lsb_first_i,
  input  logic [7:0] rd_data_i,
  output logic [6:0] rd_addr_o,
  output wr_req_t    wr_o,
  output logic       tx_bit_o,
  output logic       tx_en_o
);
  logic       sclk_q;
  logic       rise, fall;
  logic [4:0] bit_cnt;
  logic [7:0] rx_sh, rx_next, rx_byte;
  logic [7:0] instr;
  logic       rd_ph, tx_first, tx_bit;
  logic [7:0] tx_sh, tx_ord;

  assign rise    = sclk_i & ~sclk_q;
  assign fall    = ~sclk_i & sclk_q;
  assign rx_next = {rx_sh[6:0], sdi_i};
  assign rx_byte = lsb_first_i ? bit_rev(rx_next) : rx_next;
  assign tx_ord  = lsb_first_i ? bit_rev(rd_data_i) : rd_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt  <= '0;
      rx_sh    <= '0;
      instr    <= '0;
      rd_ph    <= 1'b0;
      tx_first <= 1'b1;
      tx_bit   <= 1'b0;
      tx_sh    <= '0;
      wr_o     <= '0;
    end else begin
      wr_o.we <= 1'b0;
      if (cs_n_i) begin
        bit_cnt  <= '0;
        rd_ph    <= 1'b0;
        tx_first <= 1'b1;
        tx_bit   <= 1'b0;
      end else begin
        if (rise && bit_cnt != 5'd16) begin
          rx_sh   <= rx_next;
          bit_cnt <= bit_cnt + 5'd1;
          if (bit_cnt == 5'd7) begin
            instr <= rx_byte;
            rd_ph <= rx_byte[7];
          end
          if (bit_cnt == 5'd15 && !instr[7]) begin
            wr_o.we   <= 1'b1;
            wr_o.addr <= instr[6:0];
            wr_o.data <= rx_byte;
          end
        end
        if (fall && rd_ph) begin
          // snapshot read data on the first falling edge of the data phase
          if (tx_first) begin
            tx_bit   <= tx_ord[7];
            tx_sh    <= {tx_ord[6:0], 1'b0};
            tx_first <= 1'b0;
          end else begin
            tx_bit <= tx_sh[7];
            tx_sh  <= {tx_sh[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign rd_addr_o = instr[6:0];
  assign tx_bit_o  = tx_bit;
  assign tx_en_o   = rd_ph;

  // R2
  wr_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o.we |-> (bit_cnt == 5'd16 && !instr[7]));
  // R3
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fall && !cs_n_i) |=> $stable(tx_bit));
  // R8
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> (bit_cnt == 5'd0 && !wr_o.we && !rd_ph));
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_cfg_pkg::*;
#(
  parameter int unsigned MEM_DATA_W = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  wr_req_t               wr_i,
  input  logic [6:0]            rd_addr_i,
  output logic [7:0]            rd_data_o,
  input  logic                  sync_alarm_i,
  input  logic [1:0]            sync_quad_i,
  output logic [7:0]            mode_o,
  output logic [7:0]            dclk_o,
  output logic [7:0]            madr_o,
  output logic [MEM_DATA_W-1:0] mdat_o,
  output logic [7:0]            sqi_o
);
  logic [7:0]            r00, r02, r10, r16;
  logic [MEM_DATA_W-1:0] r11;
  logic                  srst, no_store;

  assign srst     = wr_i.we && wr_i.addr == A_MODE && wr_i.data[SRST_BIT];
  assign no_store = !(wr_i.addr inside {A_MODE, A_DCLK, A_MADR, A_MDAT, A_SQI});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r00 <= '0; r02 <= '0; r10 <= '0; r11 <= '0; r16 <= '0;
    end else if (srst) begin
      r00 <= wr_i.data & M_MODE;
      r02 <= '0; r10 <= '0; r11 <= '0; r16 <= '0;
    end else if (wr_i.we) begin
      case (wr_i.addr)
        A_MODE:  r00 <= wr_i.data & M_MODE;
        A_DCLK:  r02 <= wr_i.data & M_DCLK;
        A_MADR:  r10 <= wr_i.data;
        A_MDAT:  r11 <= wr_i.data[MEM_DATA_W-1:0];
        A_SQI:   r16 <= wr_i.data & M_SQI;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_MODE: rd_data_o = r00;
      A_DCLK: rd_data_o = {r02[7:1], sync_alarm_i};
      A_MADR: rd_data_o = r10;
      A_MDAT: rd_data_o[MEM_DATA_W-1:0] = r11;
      A_SQO:  rd_data_o[1:0] = sync_quad_i;
      A_SQI:  rd_data_o = r16;
      default: ;
    endcase
  end

  assign mode_o = r00;
  assign dclk_o = r02;
  assign madr_o = r10;
  assign mdat_o = r11;
  assign sqi_o  = r16;

  // R7
  unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i.we && no_store) |=> $stable({r00, r02, r10, r11, r16}));
  // R9
  srst_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (r02 == '0 && r10 == '0 && r11 == '0 && r16 == '0 && !r00[SRST_BIT]));
endmodule

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs
  import spi_cfg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MEM_DATA_W  = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sclk_i,
  input  logic                  cs_ni,
  input  logic                  sdio_i,
  output logic                  sdio_o,
  output logic                  sdio_oe_o,
  output logic                  sdo_o,
  output logic                  sdo_oe_o,
  input  logic                  sync_alarm_i,
  input  logic [1:0]            sync_quad_i,
  output logic [7:0]            mode_cfg_o,
  output logic [7:0]            dclk_cfg_o,
  output logic [7:0]            mem_addr_o,
  output logic [MEM_DATA_W-1:0] mem_data_o,
  output logic [7:0]            sync_cfg_o
);
  localparam int unsigned NPIN = 3;

  logic [NPIN-1:0] pins_s;
  logic            cs_s, sclk_s, sdi_s;
  logic [6:0]      rd_addr;
  logic [7:0]      rd_data;
  wr_req_t         wr;
  logic            tx_bit, tx_en, wire3;

  spi_in_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({cs_ni, sclk_i, sdio_i}),
    .q_o (pins_s)
  );
  assign {cs_s, sclk_s, sdi_s} = pins_s;

  spi_serial_engine u_eng (
    .clk_i, .rst_ni,
    .cs_n_i      (cs_s),
    .sclk_i      (sclk_s),
    .sdi_i       (sdi_s),
    .lsb_first_i (mode_cfg_o[LSB_BIT]),
    .rd_data_i   (rd_data),
    .rd_addr_o   (rd_addr),
    .wr_o        (wr),
    .tx_bit_o    (tx_bit),
    .tx_en_o     (tx_en)
  );

  spi_reg_bank #(.MEM_DATA_W(MEM_DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_i         (wr),
    .rd_addr_i    (rd_addr),
    .rd_data_o    (rd_data),
    .sync_alarm_i,
    .sync_quad_i,
    .mode_o       (mode_cfg_o),
    .dclk_o       (dclk_cfg_o),
    .madr_o       (mem_addr_o),
    .mdat_o       (mem_data_o),
    .sqi_o        (sync_cfg_o)
  );

  assign wire3     = mode_cfg_o[WIRE3_BIT];
  assign sdio_o    = tx_bit & wire3;
  assign sdio_oe_o = tx_en & wire3;
  assign sdo_o     = tx_bit & ~wire3;
  assign sdo_oe_o  = tx_en & ~wire3;

  // R4
  oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> (!sdio_oe_o && !sdo_oe_o));
endmodule

// File: tb/tb_spi_ctrl_regs.sv
module tb_spi_ctrl_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sync_alarm = 1'b0;
  logic [1:0] sync_quad = 2'd0;
  logic sdio_o, sdio_oe, sdo_o, sdo_oe;
  logic [7:0] mode_cfg, dclk_cfg, mem_addr, sync_cfg;
  logic [5:0] mem_data;

  int vectors = 0, errors = 0;
  bit cmp_en = 1'b0, done = 1'b0;
  logic [7:0] m00 = 0, m02 = 0, m10 = 0, m16 = 0;
  logic [5:0] m11 = 0;

  always #5 clk = ~clk;

  spi_ctrl_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .sdio_i(sdi),
    .sdio_o(sdio_o), .sdio_oe_o(sdio_oe), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe),
    .sync_alarm_i(sync_alarm), .sync_quad_i(sync_quad),
    .mode_cfg_o(mode_cfg), .dclk_cfg_o(dclk_cfg), .mem_addr_o(mem_addr),
    .mem_data_o(mem_data), .sync_cfg_o(sync_cfg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model: register image compared on every clock while idle
  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R6/R7/R9 mode", mode_cfg, m00);
      chk("R6/R7/R9 dclk", dclk_cfg, m02);
      chk("R7/R8 madr", mem_addr, m10);
      chk("R6/R9 mdat", mem_data, m11);
      chk("R6/R9 sqi", sync_cfg, m16);
      chk("R4 idle oe", {sdio_oe, sdo_oe}, 2'b00);
    end
  end

  function automatic logic [7:0] exp_rd(input logic [6:0] a);
    case (a)
      7'h00: return m00;
      7'h02: return {m02[7:1], sync_alarm};
      7'h10: return m10;
      7'h11: return {2'b00, m11};
      7'h15: return {6'd0, sync_quad};
      7'h16: return m16;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_wr(input logic [6:0] a, input logic [7:0] d);
    if (a == 7'h00 && d[5]) begin
      m00 = d & 8'hD9; m02 = 0; m10 = 0; m11 = 0; m16 = 0;
    end else case (a)
      7'h00: m00 = d & 8'hD9;
      7'h02: m02 = d & 8'hFE;
      7'h10: m10 = d;
      7'h11: m11 = d[5:0];
      7'h16: m16 = d & 8'h78;
      default: ;
    endcase
  endtask

  task automatic xfer(input logic rw, input logic [6:0] a, input logic [7:0] wd,
                      input int nbits, input string req, output logic [7:0] rd);
    logic [7:0] ins, b;
    logic lsb, w3, v, oe, oe_other;
    int idx;
    ins = {rw, a};
    lsb = m00[6];
    w3  = m00[7];
    rd  = 8'h00;
    cmp_en = 1'b0;
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      b   = (i < 8) ? ins : wd;
      idx = i % 8;
      sdi = lsb ? b[idx] : b[7-idx];
      repeat (8) @(negedge clk);
      if (rw && i >= 8) begin
        v        = w3 ? sdio_o : sdo_o;
        oe       = w3 ? sdio_oe : sdo_oe;
        oe_other = w3 ? sdo_oe : sdio_oe;
        if (lsb) rd[i-8] = v; else rd[15-i] = v;
        if (i == 8) begin
          chk({req, " R4 data-phase oe"}, {oe, oe_other}, 2'b10);
        end
      end
      if (i == 4) chk({req, " R4 instr-phase oe"}, {sdio_oe, sdo_oe}, 2'b00);
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    sdi  = 1'b0;
    repeat (12) @(negedge clk);
    if (nbits >= 16 && !rw) model_wr(a, wd);
    cmp_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d, input string req);
    logic [7:0] dummy;
    xfer(1'b0, a, d, 16, req, dummy);
  endtask

  task automatic rd_chk(input logic [6:0] a, input string req);
    logic [7:0] r;
    xfer(1'b1, a, 8'h00, 16, req, r);
    chk({req, " readback"}, r, exp_rd(a));
  endtask

  task automatic abort(input logic [6:0] a, input logic [7:0] d, input int n, input string req);
    logic [7:0] dummy;
    xfer(1'b0, a, d, n, req, dummy);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode_cfg, 0); chk("R1 dclk", dclk_cfg, 0);
    chk("R1 madr", mem_addr, 0); chk("R1 mdat", mem_data, 0);
    chk("R1 sqi", sync_cfg, 0);  chk("R1 oe", {sdio_oe, sdo_oe}, 0);
    cmp_en = 1'b1;

    // R2/R3 basic 4-wire MSB-first write and read
    wr(7'h10, 8'hA5, "R2");
    rd_chk(7'h10, "R2/R3 madr");
    rd_chk(7'h00, "R3 mode");
    // R6 masks and read-only bits
    wr(7'h11, 8'hFF, "R6");
    rd_chk(7'h11, "R6 mdat");
    wr(7'h02, 8'hFF, "R6");
    sync_alarm = 1'b1;
    rd_chk(7'h02, "R6 alarm=1");
    sync_alarm = 1'b0;
    rd_chk(7'h02, "R6 alarm=0");
    sync_quad = 2'd2;
    wr(7'h15, 8'hFF, "R6 ro write");
    rd_chk(7'h15, "R6 quad");
    wr(7'h16, 8'hFF, "R6");
    rd_chk(7'h16, "R6 sqi");
    // R7 unmapped
    wr(7'h05, 8'h33, "R7");
    rd_chk(7'h05, "R7 unmapped");
    rd_chk(7'h7F, "R7 unmapped top");
    // R8 aborts
    abort(7'h10, 8'h11, 12, "R8 at 12");
    abort(7'h10, 8'h22, 15, "R8 at 15");
    abort(7'h10, 8'h33, 4, "R8 at 4");
    rd_chk(7'h10, "R8 madr kept");
    // R5 LSB first
    wr(7'h00, 8'h40, "R5 set lsb");
    wr(7'h10, 8'h3C, "R5");
    rd_chk(7'h10, "R5 lsb madr");
    wr(7'h11, 8'h05, "R5");
    rd_chk(7'h11, "R5 lsb mdat");
    // R4 3-wire
    wr(7'h00, 8'hC0, "R4 set 3-wire");
    rd_chk(7'h10, "R4 3w lsb");
    wr(7'h00, 8'h80, "R4 3w msb");
    rd_chk(7'h10, "R4 3w msb");
    rd_chk(7'h16, "R4 3w sqi");
    // R10 power bits keep port alive
    wr(7'h00, 8'hD9, "R10 set");
    chk("R10 mode bits", mode_cfg, 8'hD9);
    wr(7'h10, 8'h81, "R10");
    rd_chk(7'h10, "R10 port alive");
    // R9 soft reset keeps mode bits, clears the rest
    wr(7'h02, 8'h56, "R9 fill");
    wr(7'h16, 8'h28, "R9 fill");
    wr(7'h00, 8'hE0, "R9 srst");
    chk("R9 mode kept", mode_cfg, 8'hC0);
    chk("R9 madr cleared", mem_addr, 8'h00);
    rd_chk(7'h00, "R9 srst self-clear");
    rd_chk(7'h11, "R9 mdat cleared");
    wr(7'h00, 8'h20, "R9 srst to default");
    chk("R9 mode default", mode_cfg, 8'h00);
    rd_chk(7'h02, "R9 dclk cleared");
    repeat (20) @(negedge clk);
    done = 1'b1;
    cmp_en = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule